// File: doc/BRIEF.md
# Serial Interface Status Flag Register

This block holds the status flags of a serial transmitter/receiver pair and turns them into interrupt requests. The transmit and receive datapaths send it one-cycle event pulses. Each pulse sets one sticky flag:

- transmit buffer empty
- transmission complete
- receive buffer full
- receiver idle
- overrun
- noise
- framing error
- parity error

A CPU reads the flags through a small register bus. The bus has a read-only status word, a data-register address and an error-enable register. The data buffer itself lives elsewhere; this block only sees the strobes that access it.

A flag is cleared by a two-step bus sequence. First, a status read arms every flag that is set at that moment. Then an access to the data register clears the armed flags of the matching kind:

- A data write clears the two transmit-side flags.
- A data read clears the six receive-side flags.

The transmit interrupt follows the transmit-empty flag when the external transmit-interrupt enable pin is high. The error interrupt combines the noise, framing and parity flags, each gated by its own enable bit.

No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain control or status level, or a single-cycle strobe.

Top module: `uflg_top`

## Requirements
- R1: After reset, the status word is 8'hC0 (only bits 7 and 6 set), the enable register reads 0, and both interrupt requests are low.
- R2: Status bit positions are: 7 transmit empty, 6 transmission complete, 5 receive full, 4 idle, 3 overrun, 2 noise, 1 framing error, 0 parity error. Bit i of `set_ev` sets status bit i on the next clock edge, and the bit stays set until it is cleared.
- R3: Bits 7 and 6 clear on the clock edge of a data-register write (address 1) that follows a status read (address 0) which saw the bit set.
- R4: Bits 5 to 0 clear on the clock edge of a data-register read (address 1) that follows a status read which saw the bit set.
- R5: A data access with no arming status read before it leaves the flags unchanged. An arm covers only the flags that were set at the status read. An arm is consumed by the next matching data access, even when the flag survives that access.
- R6: The wrong kind of data access does not clear a flag and does not consume its arm. For bits 7 and 6 the wrong kind is a data read; for bits 5 to 0 it is a data write.
- R7: If a set pulse and a clearing access for the same flag fall in the same cycle, the flag stays 1.
- R8: `irq_tx` is high exactly when status bit 7 is set and `tx_irq_en` is 1.
- R9: The enable register is at address 2. Bit 2 enables noise, bit 1 enables framing and bit 0 enables parity. It is read/write, and its bits 7 to 3 read 0. `irq_err` is the OR of status bits 2, 1 and 0, each ANDed with its enable bit. Overrun never drives `irq_err`.
- R10: A bus write to the status address (0) has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_ev | input | 8 | One-cycle set pulses, one bit per status bit position |
| bus_addr | input | 2 | Register select: 0 status, 1 data, 2 error enables |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (0 for the data address) |
| tx_irq_en | input | 1 | Transmit interrupt enable level |
| stat_q | output | 8 | Current status flags, observable without arming |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The assertions check, on every cycle, the properties that hold from one edge to the next:

- a set pulse always leaves its flag at 1;
- a flag never falls unless it was armed and hit by its matching data access;
- an unarmed flag holds its value;
- writes to the status address leave the flags alone;
- the enable bits change only on writes to their own address.

Some behaviour only the bench scenarios can show. These are the full arm-then-clear sequences for each flag, the handling of the wrong access kind, and the rule that a flag set after the arming read survives. The bench also sweeps every enable setting against every pattern of error flags, checking the error interrupt against its arithmetic definition.

// File: rtl/uflg_pkg.sv
package uflg_pkg;
  localparam int NFLAG  = 8;
  localparam int NTXF   = 2;            // flags cleared by a data write (top bits)
  localparam int NERR   = 3;            // error flags with enables (bottom bits)
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] A_ENAB = 2'd2;

  localparam int B_TXE = 7;

  typedef logic [NFLAG-1:0] flag_vec_t;
  typedef logic [NERR-1:0]  err_en_t;
endpackage

// File: rtl/uflg_cell.sv
module uflg_cell #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic q_o
);
  logic q, armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q     <= RST_VAL;
      armed <= 1'b0;
    end else begin
      if (arm_i)      armed <= q;
      else if (clr_i) armed <= 1'b0;
      if (set_i)               q <= 1'b1;
      else if (clr_i && armed) q <= 1'b0;
    end
  end

  assign q_o = q;

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  p_fall_after_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !(armed && clr_i)) |=> q);
  p_unarmed_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !armed && !arm_i) |=> q);
endmodule

// File: rtl/uflg_ctl.sv
module uflg_ctl
  import uflg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output err_en_t           en_o
);
  err_en_t en;

  always_ff @(posedge clk) begin
    if (!rst_n)    en <= '0;
    else if (wr_i) en <= wdata_i[NERR-1:0];
  end

  assign en_o = en;

  p_enables_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> (en == $past(en)));
endmodule

// File: rtl/uflg_irq.sv
module uflg_irq
  import uflg_pkg::*;
(
  input  flag_vec_t flags_i,
  input  err_en_t   en_i,
  input  logic      tx_en_i,
  output logic      irq_tx_o,
  output logic      irq_err_o
);
  assign irq_tx_o  = flags_i[B_TXE] & tx_en_i;
  assign irq_err_o = |(flags_i[NERR-1:0] & en_i);
endmodule

// File: rtl/uflg_top.sv
module uflg_top
  import uflg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  set_ev,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_irq_en,
  output logic [NFLAG-1:0]  stat_q,
  output logic              irq_tx,
  output logic              irq_err
);
  logic stat_rd, data_rd, data_wr, en_wr;
  flag_vec_t flags;
  err_en_t   en;

  assign stat_rd = bus_rd && (bus_addr == A_STAT);
  assign data_rd = bus_rd && (bus_addr == A_DATA);
  assign data_wr = bus_wr && (bus_addr == A_DATA);
  assign en_wr   = bus_wr && (bus_addr == A_ENAB);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    if (i >= NFLAG - NTXF) begin : g_tx
      uflg_cell #(.RST_VAL(1'b1)) u_cell (
        .clk(clk), .rst_n(rst_n), .set_i(set_ev[i]),
        .arm_i(stat_rd), .clr_i(data_wr), .q_o(flags[i]));
    end else begin : g_rx
      uflg_cell #(.RST_VAL(1'b0)) u_cell (
        .clk(clk), .rst_n(rst_n), .set_i(set_ev[i]),
        .arm_i(stat_rd), .clr_i(data_rd), .q_o(flags[i]));
    end
  end

  uflg_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_i(en_wr), .wdata_i(bus_wdata), .en_o(en));

  uflg_irq u_irq (
    .flags_i(flags), .en_i(en), .tx_en_i(tx_irq_en),
    .irq_tx_o(irq_tx), .irq_err_o(irq_err));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT)      bus_rdata[NFLAG-1:0] = flags;
    else if (bus_addr == A_ENAB) bus_rdata[NERR-1:0]  = en;
  end

  assign stat_q = flags;

  p_stat_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && set_ev == '0) |=> (flags == $past(flags)));
endmodule

// File: tb/test_uflg_top.sv
module test_uflg_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] set_ev = '0;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tx_irq_en = 1'b0;
  logic [7:0] stat_q;
  logic       irq_tx, irq_err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uflg_top i_uflg_top (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_irq_en(tx_irq_en), .stat_q(stat_q),
    .irq_tx(irq_tx), .irq_err(irq_err));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus/event cycle: drive after a falling edge, hold over one rising edge
  task automatic cyc(logic [7:0] ev, logic [1:0] a, logic rd, logic wr, logic [7:0] wd);
    set_ev = ev; bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    @(negedge clk);
    set_ev = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic stat_read(output logic [7:0] v);
    bus_addr = 2'd0; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // right clearing access for a bit: data write for 7..6, data read for 5..0
  task automatic right_acc(int b, logic [7:0] ev);
    if (b >= 6) cyc(ev, 2'd1, 1'b0, 1'b1, 8'h00);
    else        cyc(ev, 2'd1, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic wrong_acc(int b);
    if (b >= 6) cyc('0, 2'd1, 1'b1, 1'b0, 8'h00);
    else        cyc('0, 2'd1, 1'b0, 1'b1, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 status", stat_q, 8'hC0);
    bus_addr = 2'd2; #1 check("R1 enables", bus_rdata, 8'h00);
    check("R1 irqs", {6'd0, irq_tx, irq_err}, 8'h00);

    // R10 write to status address
    cyc('0, 2'd0, 1'b0, 1'b1, 8'h00);
    check("R10 status write ignored", stat_q, 8'hC0);

    // R3 clear both transmit flags
    stat_read(rv);
    check("R2 status read", rv, 8'hC0);
    cyc('0, 2'd1, 1'b0, 1'b1, 8'h55);
    check("R3 tx flags cleared", stat_q, 8'h00);

    // per-bit sweep
    for (int b = 0; b < 8; b++) begin
      logic [7:0] m;
      m = 8'(1 << b);
      cyc(m, 2'd3, 1'b0, 1'b0, 8'h00);
      check("R2 set", stat_q, m);
      cyc('0, 2'd3, 1'b0, 1'b0, 8'h00);
      check("R2 sticky", stat_q, m);
      right_acc(b, '0);
      check("R5 unarmed access", stat_q, m);
      stat_read(rv);
      check("R2 rdata position", rv, m);
      wrong_acc(b);
      check("R6 wrong kind", stat_q, m);
      right_acc(b, '0);
      check(b >= 6 ? "R3 clear" : "R4 clear", stat_q, 8'h00);
    end

    // R7 set wins, arm consumed
    foreach (rv[k]) begin end
    for (int j = 0; j < 2; j++) begin
      int b;
      logic [7:0] m;
      b = (j == 0) ? 7 : 0;
      m = 8'(1 << b);
      cyc(m, 2'd3, 1'b0, 1'b0, 8'h00);
      stat_read(rv);
      right_acc(b, m);
      check("R7 set wins", stat_q, m);
      right_acc(b, '0);
      check("R5 arm consumed", stat_q, m);
      stat_read(rv);
      right_acc(b, '0);
      check("R7 cleared after", stat_q, 8'h00);
    end

    // R5 flag set after the arming read survives
    stat_read(rv);
    cyc(8'h01, 2'd3, 1'b0, 1'b0, 8'h00);
    cyc('0, 2'd1, 1'b1, 1'b0, 8'h00);
    check("R5 late set survives", stat_q, 8'h01);
    stat_read(rv);
    cyc('0, 2'd1, 1'b1, 1'b0, 8'h00);
    check("R4 clear pe", stat_q, 8'h00);

    // R8 transmit interrupt
    check("R8 irq_tx low when empty clear", {7'd0, irq_tx}, 8'h00);
    cyc(8'h80, 2'd3, 1'b0, 1'b0, 8'h00);
    tx_irq_en = 1'b0; #1 check("R8 irq_tx disabled", {7'd0, irq_tx}, 8'h00);
    tx_irq_en = 1'b1; #1 check("R8 irq_tx enabled", {7'd0, irq_tx}, 8'h01);
    stat_read(rv);
    cyc('0, 2'd1, 1'b0, 1'b1, 8'h00);
    check("R8 irq_tx after clear", {7'd0, irq_tx}, 8'h00);
    tx_irq_en = 1'b0;

    // R9 sweep of enables against error flag patterns (bits 3..0)
    for (int e = 0; e < 8; e++) begin
      cyc('0, 2'd2, 1'b0, 1'b1, 8'hF8 | 8'(e));
      bus_addr = 2'd2; #1 check("R9 enable readback", bus_rdata, 8'(e));
      for (int p = 0; p < 16; p++) begin
        logic exp_irq;
        exp_irq = |(p[2:0] & e[2:0]);
        cyc(8'(p), 2'd3, 1'b0, 1'b0, 8'h00);
        check("R9 irq_err", {7'd0, irq_err}, {7'd0, exp_irq});
        stat_read(rv);
        cyc('0, 2'd1, 1'b1, 1'b0, 8'h00);
      end
    end
    check("R4 flags clear after sweep", stat_q, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule